// File: doc/BRIEF.md
# Pad Pull-Resistor Latch Sequencer

This block holds the pull-resistor setting of every pad in a bank of general-purpose pins and drives each pad's pull-up and pull-down enables. Pins have no pull register of their own. Software instead loads one global two-bit pull code into a control register. After a settling interval it raises strobe bits, one per pin, in two strobe registers of `BANK_W` bits each. Pin `p` uses bit `p mod BANK_W` of strobe register `p / BANK_W`. A pin takes the global code only when two conditions both hold: the code was left untouched for the whole setup interval before its strobe bit rose, and the strobe bit then stayed high for the full hold interval.

Writes arrive on a single write-only port. Address 0 is the control register, which uses only `wrData[1:0]`. Address `1 + b` is strobe register `b`. No path reads anything back. The captured codes are visible only as the pad enables.

Top module: `pull_seq`

## Requirements
- R1: After reset, and again whenever reset is applied later, every pin holds `RESET_CODE` (default: no pull), so both of its enables are low.
- R2: Code decoding is as follows. 1 sets only `pullDnEn`. 2 sets only `pullUpEn`. 0 and the reserved code 3 leave both low. `pullUpEn` and `pullDnEn` are never high together on any pin.
- R3: A strobe bit that rises at least `SETUP_CYCLES` idle cycles after the last control write loads the control code into its pin. The new enables appear `HOLD_CYCLES` cycles after the strobe write, provided that neither the control register nor that pin's strobe register is written in between.
- R4: A strobe bit that rises fewer than `SETUP_CYCLES` idle cycles after a control write captures nothing, and the pin keeps its old code.
- R5: A strobe bit that is cleared fewer than `HOLD_CYCLES` cycles after it rose leaves the pin's old code in place.
- R6: A control write during a pending hold abandons the capture. The pin keeps its old code even though its strobe bit stays high.
- R7: Only pins whose strobe bit rose change their code. All other pins in both strobe registers keep their code.
- R8: Strobe bits above the last pin and control bits above bit 1 are ignored.
- R9: A strobe bit left high after a capture does not capture again when the control code later changes. Only a new rising edge captures.
- R10: Any write to a strobe register restarts the hold interval for every pending pin of that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one write per cycle |
| wrAddr | input | ADDR_W | 0 = pull code, 1 + b = strobe register b |
| wrData | input | BANK_W | Write data |
| pullUpEn | output | NUM_PINS | Per-pin pull-up enable |
| pullDnEn | output | NUM_PINS | Per-pin pull-down enable |

## Verification
The hardest cases to reach sit exactly on the timing limits. A strobe that rises one cycle too early after a code write must capture nothing. A strobe that is cleared one cycle before the hold interval ends must also capture nothing. A rewrite in the middle of a hold must push the capture out by a full interval. The stimulus table places the code write, the strobe write and the strobe clear at idle gaps equal to the limit and one below it. Directed sequences then rewrite the code or the strobe register in the middle of a hold and sample the pads at the first cycle the capture is allowed.

// File: rtl/pull_seq_pkg.sv
package pull_seq_pkg;

  typedef enum logic [1:0] {
    PULL_NONE = 2'd0,
    PULL_DOWN = 2'd1,
    PULL_UP   = 2'd2,
    PULL_RSVD = 2'd3
  } pull_code_e;

  // Strobes passed from the sequencing control to the pin state storage.
  typedef struct packed {
    logic       commit;
    pull_code_e code;
  } pull_strobe_t;

endpackage

// File: rtl/pull_seq_ctrl.sv
module pull_seq_ctrl
  import pull_seq_pkg::*;
#(
  parameter int NUM_PINS     = 54,
  parameter int BANK_W       = 32,
  parameter int SETUP_CYCLES = 150,
  parameter int HOLD_CYCLES  = 150,
  parameter int ADDR_W       = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [BANK_W-1:0]   wrData,
  output pull_strobe_t        strobe,
  output logic [NUM_PINS-1:0] commitMask
);

  localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
  localparam int SETUP_W   = $clog2(SETUP_CYCLES + 1);
  localparam int HOLD_W    = $clog2(HOLD_CYCLES + 1);
  localparam logic [SETUP_W-1:0] SETUP_DONE = SETUP_W'(SETUP_CYCLES);
  localparam logic [HOLD_W-1:0]  HOLD_LAST  = HOLD_W'(HOLD_CYCLES - 1);

  function automatic logic [BANK_W-1:0] bankValid(input int b);
    logic [BANK_W-1:0] m;
    for (int i = 0; i < BANK_W; i++) m[i] = ((b * BANK_W + i) < NUM_PINS);
    return m;
  endfunction

  pull_code_e         ctrlCode;
  logic [SETUP_W-1:0] setupCnt;
  logic               setupOk;
  logic               ctrlWr;

  logic [BANK_W-1:0]  clkBits   [NUM_BANKS];
  logic [BANK_W-1:0]  pending   [NUM_BANKS];
  logic [HOLD_W-1:0]  holdCnt   [NUM_BANKS];
  logic [NUM_BANKS-1:0] bankWr;
  logic [NUM_BANKS-1:0] bankCommit;

  assign ctrlWr  = wrEn && (wrAddr == '0);
  assign setupOk = (setupCnt == SETUP_DONE);

  // Global pull code and its settling counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlCode <= PULL_NONE;
      setupCnt <= '0;
    end else if (ctrlWr) begin
      ctrlCode <= pull_code_e'(wrData[1:0]);
      setupCnt <= '0;
    end else if (!setupOk) begin
      setupCnt <= setupCnt + 1'b1;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [BANK_W-1:0] VALID = bankValid(b);
    logic [BANK_W-1:0] newBits;
    logic [BANK_W-1:0] riseBits;
    logic              anyPend;

    assign bankWr[b]  = wrEn && (wrAddr == ADDR_W'(b + 1));
    assign newBits    = wrData & VALID;
    assign riseBits   = newBits & ~clkBits[b];
    assign anyPend    = |pending[b];
    assign bankCommit[b] = anyPend && (holdCnt[b] == HOLD_LAST) && !bankWr[b] && !ctrlWr;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        clkBits[b] <= '0;
      end else if (bankWr[b]) begin
        clkBits[b] <= newBits;
      end
    end

    // Pins armed for capture: kept while their strobe stays high, dropped on
    // a code write, on an early clear, or once committed.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pending[b] <= '0;
      end else if (ctrlWr) begin
        pending[b] <= '0;
      end else if (bankWr[b]) begin
        pending[b] <= (pending[b] & newBits) | (riseBits & {BANK_W{setupOk}});
      end else if (bankCommit[b]) begin
        pending[b] <= '0;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        holdCnt[b] <= '0;
      end else if (bankWr[b]) begin
        holdCnt[b] <= '0;
      end else if (anyPend && (holdCnt[b] != HOLD_LAST)) begin
        holdCnt[b] <= holdCnt[b] + 1'b1;
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      commitMask[p] = bankCommit[p / BANK_W] & pending[p / BANK_W][p % BANK_W];
    end
  end

  assign strobe.commit = |bankCommit;
  assign strobe.code   = ctrlCode;

endmodule

// File: rtl/pull_seq_state.sv
module pull_seq_state
  import pull_seq_pkg::*;
#(
  parameter int         NUM_PINS   = 54,
  parameter pull_code_e RESET_CODE = PULL_NONE
) (
  input  logic                clk,
  input  logic                rstN,
  input  pull_strobe_t        strobe,
  input  logic [NUM_PINS-1:0] commitMask,
  output logic [NUM_PINS-1:0] pullUpEn,
  output logic [NUM_PINS-1:0] pullDnEn
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pull_code_e pinCode;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pinCode <= RESET_CODE;
      end else if (strobe.commit && commitMask[p]) begin
        pinCode <= strobe.code;
      end
    end

    // The reserved code falls through to no pull.
    assign pullUpEn[p] = (pinCode == PULL_UP);
    assign pullDnEn[p] = (pinCode == PULL_DOWN);
  end

endmodule

// File: rtl/pull_seq.sv
module pull_seq
  import pull_seq_pkg::*;
#(
  parameter int         NUM_PINS     = 54,
  parameter int         BANK_W       = 32,
  parameter int         SETUP_CYCLES = 150,
  parameter int         HOLD_CYCLES  = 150,
  parameter int         ADDR_W       = 2,
  parameter pull_code_e RESET_CODE   = PULL_NONE
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [BANK_W-1:0]   wrData,
  output logic [NUM_PINS-1:0] pullUpEn,
  output logic [NUM_PINS-1:0] pullDnEn
);

  pull_strobe_t        strobe;
  logic [NUM_PINS-1:0] commitMask;

  pull_seq_ctrl #(
    .NUM_PINS(NUM_PINS), .BANK_W(BANK_W), .SETUP_CYCLES(SETUP_CYCLES),
    .HOLD_CYCLES(HOLD_CYCLES), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .commitMask(commitMask)
  );

  pull_seq_state #(
    .NUM_PINS(NUM_PINS), .RESET_CODE(RESET_CODE)
  ) u_state (
    .clk(clk), .rstN(rstN), .strobe(strobe), .commitMask(commitMask),
    .pullUpEn(pullUpEn), .pullDnEn(pullDnEn)
  );

endmodule

// File: rtl/pull_seq_chk.sv
module pull_seq_chk
  import pull_seq_pkg::*;
#(
  parameter int NUM_PINS     = 54,
  parameter int BANK_W       = 32,
  parameter int SETUP_CYCLES = 150,
  parameter int HOLD_CYCLES  = 150,
  parameter int ADDR_W       = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [ADDR_W-1:0]   wrAddr,
  input pull_strobe_t        strobe,
  input logic [NUM_PINS-1:0] commitMask,
  input logic [NUM_PINS-1:0] pullUpEn,
  input logic [NUM_PINS-1:0] pullDnEn
);

  localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
  localparam int PAD_W     = NUM_BANKS * BANK_W;
  localparam int AGE_MAX   = SETUP_CYCLES + HOLD_CYCLES;
  localparam int AGE_W     = $clog2(AGE_MAX + 1);
  localparam int HOLD_W    = $clog2(HOLD_CYCLES + 1);

  logic [AGE_W-1:0]  ctrlAge;
  logic [PAD_W-1:0]  maskPad;
  logic [HOLD_W-1:0] bankAge [NUM_BANKS];

  assign maskPad = PAD_W'(commitMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                ctrlAge <= '0;
    else if (wrEn && wrAddr == '0)            ctrlAge <= '0;
    else if (ctrlAge != AGE_W'(AGE_MAX))      ctrlAge <= ctrlAge + 1'b1;
  end

  // R2: the two enables of a pin never overlap.
  p_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pullUpEn & pullDnEn) == '0);

  // R4: a capture needs the code settled for setup plus hold cycles.
  p_setup_age_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> (ctrlAge >= AGE_W'(AGE_MAX)));

  // R6: a code write leaves nothing to commit in the following cycle.
  p_abort_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == '0) |=> !strobe.commit);

  // R7: pads move only on a commit.
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> ($stable(pullUpEn) && $stable(pullDnEn)));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_age
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   bankAge[b] <= '0;
      else if (wrEn && wrAddr == ADDR_W'(b + 1))   bankAge[b] <= '0;
      else if (bankAge[b] != HOLD_W'(HOLD_CYCLES)) bankAge[b] <= bankAge[b] + 1'b1;
    end

    // R3 and R10: a commit for this register comes a full hold after its last write.
    p_hold_window_r3: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.commit && |maskPad[b*BANK_W +: BANK_W]) |->
        (bankAge[b] >= HOLD_W'(HOLD_CYCLES - 1)));
  end

endmodule

bind pull_seq pull_seq_chk #(
  .NUM_PINS(NUM_PINS), .BANK_W(BANK_W), .SETUP_CYCLES(SETUP_CYCLES),
  .HOLD_CYCLES(HOLD_CYCLES), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .strobe(strobe),
  .commitMask(commitMask), .pullUpEn(pullUpEn), .pullDnEn(pullDnEn)
);

// File: tb/tb_pull_seq.sv
`timescale 1ns/1ps
module tb_pull_seq;

  localparam int NP = 54;
  localparam int BW = 32;
  localparam int SU = 12;
  localparam int HD = 10;
  localparam int AW = 2;

  typedef struct packed {
    logic [3:0]  code;
    logic        bank;
    logic [31:0] bits;
    logic [7:0]  setupIdle;
    logic [7:0]  holdIdle;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{4'h1, 1'b0, 32'h0000_000F, 8'd12, 8'd10},  // R3 R2 down on pins 0-3
    '{4'h2, 1'b1, 32'h0020_0003, 8'd12, 8'd10},  // R7 up on pins 32,33,53
    '{4'h2, 1'b0, 32'h0000_00F0, 8'd11, 8'd10},  // R4 one idle cycle short
    '{4'h1, 1'b0, 32'h0000_0030, 8'd12, 8'd9 },  // R5 cleared one cycle early
    '{4'hF, 1'b0, 32'h0000_0003, 8'd12, 8'd10},  // R2 reserved code, R8 upper bits
    '{4'h6, 1'b1, 32'hFFC0_0100, 8'd12, 8'd10},  // R8 bits past last pin
    '{4'h0, 1'b1, 32'h0000_0001, 8'd40, 8'd30},  // R3 long gaps
    '{4'h1, 1'b0, 32'h8000_0000, 8'd12, 8'd10},  // R7 top bit of first register
    '{4'h2, 1'b0, 32'h0000_0008, 8'd0,  8'd10},  // R4 strobe right after code
    '{4'h2, 1'b1, 32'h0000_0002, 8'd12, 8'd0 }   // R5 immediate clear
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [BW-1:0] wrData = '0;
  logic [NP-1:0] pullUpEn, pullDnEn;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int model [NP];

  always #2 clk = ~clk;

  pull_seq #(.NUM_PINS(NP), .BANK_W(BW), .SETUP_CYCLES(SU), .HOLD_CYCLES(HD),
             .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pullUpEn(pullUpEn), .pullDnEn(pullDnEn));

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [BW-1:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic modelReset();
    for (int p = 0; p < NP; p++) model[p] = 0;
  endtask

  task automatic modelLoad(input int bank, input logic [31:0] bits, input int code);
    for (int i = 0; i < BW; i++) begin
      if (bits[i] && (bank * BW + i) < NP) model[bank * BW + i] = code;
    end
  endtask

  task automatic checkPads(input string req);
    logic [NP-1:0] expU, expD;
    for (int p = 0; p < NP; p++) begin
      expU[p] = (model[p] == 2);
      expD[p] = (model[p] == 1);
    end
    checks++;
    if (pullUpEn !== expU || pullDnEn !== expD) begin
      fails++;
      $display("FAIL %s: up=%h dn=%h expected up=%h dn=%h", req, pullUpEn, pullDnEn, expU, expD);
    end
  endtask

  initial begin
    modelReset();
    idle(3);
    checkPads("R1 pads during reset");
    rstN = 1'b1;
    idle(1);
    checkPads("R1 pads after reset");
    idle(SU);

    // Stimulus table walk.
    for (int v = 0; v < NV; v++) begin
      logic [AW-1:0] a;
      a = VECS[v].bank ? AW'(2) : AW'(1);
      busWrite('0, {28'hABCDE00, VECS[v].code});
      idle(int'(VECS[v].setupIdle));
      busWrite(a, VECS[v].bits);
      idle(int'(VECS[v].holdIdle));
      busWrite(a, '0);
      idle(2);
      if (int'(VECS[v].setupIdle) >= SU && int'(VECS[v].holdIdle) >= HD)
        modelLoad(int'(VECS[v].bank), VECS[v].bits, int'(VECS[v].code[1:0]));
      checkPads($sformatf("R3/R4/R5 vector %0d", v));
    end

    // R6: code rewritten during the hold abandons the capture.
    busWrite('0, 32'h1);
    idle(SU);
    busWrite(AW'(1), 32'h0000_0020);
    idle(3);
    busWrite('0, 32'h2);
    idle(HD + SU + 4);
    checkPads("R6 abort with strobe still high");
    busWrite(AW'(1), '0);
    idle(2);
    checkPads("R6 after clear");

    // R9: strobe left high does not recapture a later code.
    busWrite('0, 32'h2);
    idle(SU);
    busWrite(AW'(1), 32'h0000_0400);
    idle(HD);
    modelLoad(0, 32'h0000_0400, 2);
    checkPads("R3 pin 10 captured, strobe still high");
    busWrite('0, 32'h1);
    idle(SU + HD + 5);
    checkPads("R9 no recapture without new edge");
    busWrite(AW'(1), '0);
    idle(1);

    // R10: a second strobe write restarts the hold.
    busWrite('0, 32'h1);
    idle(SU);
    busWrite(AW'(1), 32'h0000_0080);
    idle(HD - 3);
    busWrite(AW'(1), 32'h0000_0180);
    idle(HD - 1);
    checkPads("R10 hold restarted, not yet captured");
    idle(1);
    modelLoad(0, 32'h0000_0180, 1);
    checkPads("R10 captured a full hold after rewrite");
    busWrite(AW'(1), '0);
    idle(1);

    // R1: reset in mid-run.
    rstN = 1'b0;
    modelReset();
    idle(2);
    checkPads("R1 mid-run reset");
    rstN = 1'b1;
    idle(2);
    checkPads("R1 after mid-run reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule